// File: doc/BRIEF.md
# Cache-Line-Aware Write Burst Planner

This block sequences the bus ownerships that carry one long memory write. Software or a DMA engine hands it a start word address, a word count, a cache line size and a maximum burst length. From then on, each time the block asks for the bus it presents the command and burst length for the coming ownership. The command is either write-and-invalidate or plain memory write. While it holds the bus it counts accepted data phases. It keeps the current address and the remaining count from one ownership to the next, and it flags completion.

Write-and-invalidate is used only for whole, aligned cache lines. Each such burst is the largest multiple of the line that fits in both the remaining data and the maximum burst. A leading run of words up to the first line boundary goes out as a plain write. So does a tail shorter than one line. Each of the following ends the current ownership and makes the block request the bus again:

- a latency timer expiry (for write-and-invalidate, only once the next line boundary is reached);
- a target retry;
- a target disconnect.

The command for the new ownership is chosen again from the address reached.

The bus electrical protocol, arbitration and data storage are outside the block. They appear only as single-wire strobes: grant, acknowledge, latency expiry, retry and disconnect.

Top module: `write_burst_planner`

## Requirements
- R1: A start pulse while idle or done captures address, count, line size and maximum burst. A maximum of 0 is taken as 1. bus_req is high in the next cycle, and cmd_mwi/burst_len show the plan for the coming ownership while bus_req is high and no ownership is in progress.
- R2: When the current address is not a multiple of the line size (line size nonzero, maximum at least one line), the plan is a plain write (cmd_mwi=0) of min(words to the next line boundary, remaining) words.
- R3: When the address is on a line boundary and at least one line remains (with the maximum at least one line), the plan is write-and-invalidate (cmd_mwi=1). Its length is the largest multiple of the line size not above min(remaining, maximum).
- R4: The plan is recomputed at every ownership from the current address and remaining count. Bursts therefore step down near the end, and a final remainder below one line is a plain write of exactly that remainder.
- R5: When the maximum burst equals the line size, every write-and-invalidate burst is exactly one line.
- R6: With a line size of 0, or a maximum below the line size, every burst is a plain write of min(remaining, maximum) words.
- R7: Each acknowledged data phase during an ownership adds 1 to cur_addr and subtracts 1 from rem_words. An acknowledge outside an ownership changes neither.
- R8: On latency expiry during a write-and-invalidate ownership, data continues until the address reaches the next line boundary, then the ownership ends. During a plain-write ownership it ends at once. Either way bus_req stays high for the next ownership.
- R9: A retry accepts no data in its cycle, even if acknowledge is also high. The ownership ends with the address unchanged, and the next ownership repeats the same write-and-invalidate plan.
- R10: A disconnect ends the ownership after counting any acknowledge in the same cycle. The next ownership uses write-and-invalidate only if the address reached is line aligned; otherwise it uses a plain write up to the boundary.
- R11: In the cycle after the final data phase, done is 1 and bus_req is 0. This holds until the next start. A start with a count of 0 goes directly to done without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new transfer (taken while idle or done) |
| start_addr | input | ADDR_W | First word address |
| start_count | input | CNT_W | Number of 32-bit words |
| line_words | input | LINE_W | Cache line size in words (0 or a power of two up to 128) |
| max_burst | input | CNT_W | Largest burst length in words |
| bus_grant | input | 1 | Ownership granted (taken while requesting) |
| data_ack | input | 1 | One data phase accepted by the target |
| lat_expire | input | 1 | Latency timer ran out |
| tgt_retry | input | 1 | Target stop with no data |
| tgt_disc | input | 1 | Target disconnect |
| bus_req | output | 1 | Bus request |
| cmd_mwi | output | 1 | 1 = write-and-invalidate, 0 = plain memory write |
| burst_len | output | CNT_W | Planned or running burst length in words |
| done | output | 1 | Transfer complete |
| cur_addr | output | ADDR_W | Current word address |
| rem_words | output | CNT_W | Words still to transfer |

## Verification
The plan (cmd_mwi, burst_len) is combinational from registered state. It is therefore due in the first cycle after a start or after an ownership ends, and it holds until the grant edge. The scoreboard monitor compares it in the grant cycle, 4 ns after the falling edge, against an entry the driver queued just before raising the grant.

cur_addr and rem_words move one cycle after each acknowledged phase. done and the dropped request appear one cycle after the final acknowledge. The driver checks both at the falling edge that follows the last driven phase of each ownership. Latency, retry and disconnect are driven at chosen phases, so the number of phases the bench expects in each ownership is known before it drives them.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } wbp_state_e;
endpackage

// File: rtl/wbp_cursor.sv
// Holds the transfer position and the configuration captured at start.
module wbp_cursor #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic [LINE_W-1:0] ld_line,
  input  logic [CNT_W-1:0]  ld_max,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  rem,
  output logic [LINE_W-1:0] line_q,
  output logic [CNT_W-1:0]  max_q,
  output logic              aligned_now,
  output logic              aligned_next
);
  // True when the low address bits fall on a line boundary.
  function automatic logic on_line(input logic [LINE_W-1:0] a,
                                   input logic [LINE_W-1:0] l);
    return (a & (l - LINE_W'(1))) == '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      rem    <= '0;
      line_q <= '0;
      max_q  <= CNT_W'(1);
    end else if (load) begin
      addr   <= ld_addr;
      rem    <= ld_count;
      line_q <= ld_line;
      max_q  <= (ld_max == '0) ? CNT_W'(1) : ld_max;   // R1
    end else if (step) begin
      addr <= addr + ADDR_W'(1);                        // R7
      rem  <= rem - CNT_W'(1);
    end
  end

  assign aligned_now  = on_line(addr[LINE_W-1:0], line_q);
  assign aligned_next = on_line(addr[LINE_W-1:0] + LINE_W'(1), line_q);
endmodule

// File: rtl/wbp_planner.sv
// Chooses command and length for the next ownership.
module wbp_planner #(
  parameter int CNT_W  = 16,
  parameter int LINE_W = 8
) (
  input  logic [LINE_W-1:0] addr_lo,
  input  logic [CNT_W-1:0]  rem,
  input  logic [LINE_W-1:0] line,
  input  logic [CNT_W-1:0]  maxb,
  output logic              plan_mwi,
  output logic [CNT_W-1:0]  plan_len
);
  function automatic logic [CNT_W:0] plan(input logic [LINE_W-1:0] a,
                                          input logic [CNT_W-1:0]  r,
                                          input logic [LINE_W-1:0] l,
                                          input logic [CNT_W-1:0]  m);
    logic [CNT_W-1:0] lw, mask, lim, off, gap, len;
    logic             mwi;
    lw   = CNT_W'(l);
    mask = lw - CNT_W'(1);
    lim  = (r < m) ? r : m;
    off  = CNT_W'(a) & mask;
    gap  = lw - off;
    if (lw == '0 || m < lw) begin          // R6
      mwi = 1'b0;
      len = lim;
    end else if (off != '0) begin          // R2
      mwi = 1'b0;
      len = (gap < r) ? gap : r;
    end else if (r < lw) begin             // R4 tail
      mwi = 1'b0;
      len = r;
    end else begin                         // R3
      mwi = 1'b1;
      len = lim & ~mask;
    end
    return {mwi, len};
  endfunction

  assign {plan_mwi, plan_len} = plan(addr_lo, rem, line, maxb);
endmodule

// File: rtl/wbp_seq.sv
// Ownership sequencer: request, transfer, release and completion.
module wbp_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             count_zero,
  input  logic             bus_grant,
  input  logic             data_ack,
  input  logic             lat_expire,
  input  logic             tgt_retry,
  input  logic             tgt_disc,
  input  logic             plan_mwi,
  input  logic [CNT_W-1:0] plan_len,
  input  logic [CNT_W-1:0] rem,
  input  logic             aligned_now,
  input  logic             aligned_next,
  output logic             load,
  output logic             beat,
  output logic             in_req,
  output logic             in_xfer,
  output logic             own_end,
  output logic             bus_req,
  output logic             cmd_mwi,
  output logic [CNT_W-1:0] burst_len,
  output logic             done
);
  import wbp_pkg::*;

  wbp_state_e       st_q, st_d;
  logic             own_mwi_q, lat_pend_q;
  logic [CNT_W-1:0] own_len_q, beats_q, beats_nx;
  logic             last_word, lat_now, at_line, rel_lat, grant_take, idle_like;

  assign in_req     = (st_q == ST_REQ);
  assign in_xfer    = (st_q == ST_XFER);
  assign idle_like  = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign load       = start && idle_like;
  assign grant_take = in_req && bus_grant;

  assign beat      = in_xfer && data_ack && !tgt_retry;      // R9 retry takes no data
  assign beats_nx  = beats_q + CNT_W'(beat);
  assign last_word = beat && (rem == CNT_W'(1));
  assign lat_now   = lat_pend_q || lat_expire;
  assign at_line   = beat ? aligned_next : aligned_now;
  assign rel_lat   = in_xfer && lat_now &&
                     (!own_mwi_q || (at_line && beats_nx != '0));  // R8
  assign own_end   = in_xfer && !last_word &&
                     (tgt_retry || tgt_disc || beats_nx == own_len_q || rel_lat);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start) st_d = count_zero ? ST_DONE : ST_REQ;  // R11
      ST_REQ:           if (bus_grant) st_d = ST_XFER;
      ST_XFER: begin
        if (last_word)    st_d = ST_DONE;
        else if (own_end) st_d = ST_REQ;
      end
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      own_mwi_q  <= 1'b0;
      own_len_q  <= '0;
      beats_q    <= '0;
      lat_pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (grant_take) begin
        own_mwi_q  <= plan_mwi;
        own_len_q  <= plan_len;
        beats_q    <= '0;
        lat_pend_q <= 1'b0;
      end else if (in_xfer) begin
        beats_q <= beats_nx;
        if (lat_expire) lat_pend_q <= 1'b1;
      end
    end
  end

  assign bus_req   = in_req || in_xfer;
  assign cmd_mwi   = in_req ? plan_mwi : (in_xfer ? own_mwi_q : 1'b0);
  assign burst_len = in_req ? plan_len : (in_xfer ? own_len_q : '0);
  assign done      = (st_q == ST_DONE);
endmodule

// File: rtl/write_burst_planner.sv
module write_burst_planner #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [LINE_W-1:0] line_words,
  input  logic [CNT_W-1:0]  max_burst,
  input  logic              bus_grant,
  input  logic              data_ack,
  input  logic              lat_expire,
  input  logic              tgt_retry,
  input  logic              tgt_disc,
  output logic              bus_req,
  output logic              cmd_mwi,
  output logic [CNT_W-1:0]  burst_len,
  output logic              done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  rem_words
);
  logic              load, beat, in_req, in_xfer, own_end;
  logic              aligned_now, aligned_next, plan_mwi;
  logic [CNT_W-1:0]  plan_len, max_q;
  logic [LINE_W-1:0] line_q;

  wbp_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_addr(start_addr), .ld_count(start_count),
    .ld_line(line_words), .ld_max(max_burst),
    .step(beat), .addr(cur_addr), .rem(rem_words),
    .line_q(line_q), .max_q(max_q),
    .aligned_now(aligned_now), .aligned_next(aligned_next)
  );

  wbp_planner #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_planner (
    .addr_lo(cur_addr[LINE_W-1:0]), .rem(rem_words),
    .line(line_q), .maxb(max_q),
    .plan_mwi(plan_mwi), .plan_len(plan_len)
  );

  wbp_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .count_zero(start_count == '0),
    .bus_grant(bus_grant), .data_ack(data_ack), .lat_expire(lat_expire),
    .tgt_retry(tgt_retry), .tgt_disc(tgt_disc),
    .plan_mwi(plan_mwi), .plan_len(plan_len), .rem(rem_words),
    .aligned_now(aligned_now), .aligned_next(aligned_next),
    .load(load), .beat(beat), .in_req(in_req), .in_xfer(in_xfer),
    .own_end(own_end), .bus_req(bus_req), .cmd_mwi(cmd_mwi),
    .burst_len(burst_len), .done(done)
  );
endmodule

// File: rtl/wbp_checker.sv
module wbp_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_req,
  input logic              in_xfer,
  input logic              beat,
  input logic              done,
  input logic              bus_req,
  input logic              cmd_mwi,
  input logic [CNT_W-1:0]  burst_len,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  rem_words,
  input logic [LINE_W-1:0] line_q,
  input logic [CNT_W-1:0]  max_q,
  input logic              aligned_now,
  input logic              tgt_retry
);
  logic [CNT_W-1:0] lmask;
  assign lmask = CNT_W'(line_q) - CNT_W'(1);

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);  // R11
  AST_MWI_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && cmd_mwi) |-> aligned_now);  // R3
  AST_MWI_WHOLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && cmd_mwi) |-> ((burst_len & lmask) == '0 && burst_len != '0 &&
                             burst_len <= max_q && burst_len <= rem_words));  // R3
  AST_PLAIN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && (line_q == '0 || max_q < CNT_W'(line_q))) |-> !cmd_mwi);  // R6
  AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_req |-> (burst_len != '0 && burst_len <= rem_words));  // R4
  AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (cur_addr == $past(cur_addr) + ADDR_W'(1) &&
              rem_words == $past(rem_words) - CNT_W'(1)));  // R7
  AST_RETRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && tgt_retry) |=> ($stable(cur_addr) && in_req));  // R9
endmodule

bind write_burst_planner wbp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) u_wbp_chk (
  .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_xfer(in_xfer), .beat(beat),
  .done(done), .bus_req(bus_req), .cmd_mwi(cmd_mwi), .burst_len(burst_len),
  .cur_addr(cur_addr), .rem_words(rem_words), .line_q(line_q), .max_q(max_q),
  .aligned_now(aligned_now), .tgt_retry(tgt_retry)
);

// File: tb/tb_write_burst_planner.sv
module tb_write_burst_planner;
  localparam int AW = 32, CW = 16, LW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, bus_grant, data_ack, lat_expire, tgt_retry, tgt_disc;
  logic [AW-1:0] start_addr;
  logic [CW-1:0] start_count, max_burst;
  logic [LW-1:0] line_words;
  logic bus_req, cmd_mwi, done;
  logic [CW-1:0] burst_len, rem_words;
  logic [AW-1:0] cur_addr;

  write_burst_planner #(.ADDR_W(AW), .CNT_W(CW), .LINE_W(LW)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  int m_addr, m_rem, m_line, m_max;

  typedef struct { bit mwi; int len; int addr; int rq; } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Expected plan restated by division instead of masking.
  function automatic void model_plan(output bit mwi, output int len);
    int lim;
    lim = (m_rem < m_max) ? m_rem : m_max;
    if (m_line == 0 || m_max < m_line) begin mwi = 0; len = lim; end
    else if (m_addr % m_line != 0) begin
      mwi = 0; len = m_line - (m_addr % m_line);
      if (len > m_rem) len = m_rem;
    end else if (m_rem < m_line) begin mwi = 0; len = m_rem; end
    else begin mwi = 1; len = (lim / m_line) * m_line; end
  endfunction

  // Monitor: compare the presented plan in each grant cycle.
  always @(negedge clk) begin
    exp_t e;
    #4;
    if (bus_req && bus_grant) begin
      if (exp_q.size() == 0) check(0, "R1 unexpected grant", 1, 0);
      else begin
        e = exp_q.pop_front();
        if (cmd_mwi !== e.mwi) begin
          n_cmp++; n_bad++;
          $display("FAIL R%0d cmd actual=%0d expected=%0d", e.rq, cmd_mwi, e.mwi);
        end else n_cmp++;
        if (int'(burst_len) != e.len) begin
          n_cmp++; n_bad++;
          $display("FAIL R%0d len actual=%0d expected=%0d", e.rq, burst_len, e.len);
        end else n_cmp++;
        if (int'(cur_addr) != e.addr) begin
          n_cmp++; n_bad++;
          $display("FAIL R%0d addr actual=%0d expected=%0d", e.rq, cur_addr, e.addr);
        end else n_cmp++;
      end
    end
  end

  task automatic start_job(input int a, input int c, input int l, input int m);
    @(negedge clk);
    start_addr = AW'(a); start_count = CW'(c); line_words = LW'(l); max_burst = CW'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_addr = a; m_rem = c; m_line = l; m_max = (m == 0) ? 1 : m;
    #1;
    if (c != 0) check(bus_req === 1'b1, "R1 request after start", bus_req, 1);
  endtask

  task automatic ack_n(input int n);
    for (int i = 0; i < n; i++) begin
      data_ack = 1'b1;
      @(negedge clk);
    end
    data_ack = 1'b0;
  endtask

  // kind: 0 full burst, 1 latency after k phases, 2 retry, 3 disconnect after k phases
  task automatic run_own(input int kind, input int k, input int rq);
    exp_t e;
    int n;
    bit mwi;
    int len;
    while (!bus_req) @(negedge clk);
    model_plan(mwi, len);
    e.mwi = mwi; e.len = len; e.addr = m_addr; e.rq = rq;
    exp_q.push_back(e);
    bus_grant = 1'b1;
    @(negedge clk);
    bus_grant = 1'b0;
    n = 0;
    case (kind)
      0: begin ack_n(len); n = len; end
      1: begin
        ack_n(k);
        lat_expire = 1'b1;
        @(negedge clk);
        lat_expire = 1'b0;
        n = k;
        if (mwi) begin
          ack_n((m_line - (k % m_line)) % m_line);
          n = k + (m_line - (k % m_line)) % m_line;
        end
      end
      2: begin
        data_ack = 1'b1; tgt_retry = 1'b1;
        @(negedge clk);
        data_ack = 1'b0; tgt_retry = 1'b0;
      end
      default: begin
        ack_n(k);
        data_ack = 1'b1; tgt_disc = 1'b1;
        @(negedge clk);
        data_ack = 1'b0; tgt_disc = 1'b0;
        n = k + 1;
      end
    endcase
    m_addr += n; m_rem -= n;
    #1;
    check(int'(cur_addr) == m_addr, "R7 address after ownership", int'(cur_addr), m_addr);
    check(int'(rem_words) == m_rem, "R7 remaining after ownership", int'(rem_words), m_rem);
    if (m_rem == 0) begin
      check(done === 1'b1, "R11 done after last phase", done, 1);
      check(bus_req === 1'b0, "R11 request dropped", bus_req, 0);
    end else begin
      check(bus_req === 1'b1 && done === 1'b0, "R8 re-request after ownership end", bus_req, 1);
    end
  endtask

  task automatic finish_job(input int rq);
    while (m_rem > 0) run_own(0, 0, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; bus_grant = 1'b0; data_ack = 1'b0;
    lat_expire = 1'b0; tgt_retry = 1'b0; tgt_disc = 1'b0;
    start_addr = '0; start_count = '0; line_words = '0; max_burst = '0;
    repeat (3) @(negedge clk);
    #1;
    check(bus_req === 1'b0 && done === 1'b0, "R11 reset state", bus_req, 0);
    rst_n = 1'b1;

    // R2 R3 R4: unaligned head, big aligned burst, short plain tail
    start_job(3, 40, 8, 32);
    // R7: acknowledge while only requesting is ignored
    data_ack = 1'b1;
    @(negedge clk);
    data_ack = 1'b0;
    #1;
    check(int'(cur_addr) == 3, "R7 ack outside ownership", int'(cur_addr), 3);
    run_own(0, 0, 2);
    run_own(0, 0, 3);
    run_own(0, 0, 4);

    // R4: step-down 16,16,12 then a one-word plain tail
    start_job(0, 45, 4, 16);
    finish_job(4);

    // R5: maximum equal to one line
    start_job(0, 20, 4, 4);
    finish_job(5);

    // R6: line size zero, then maximum below the line
    start_job(5, 14, 0, 6);
    finish_job(6);
    start_job(0, 12, 8, 5);
    finish_job(6);

    // R8 R9 R10 on write-and-invalidate ownerships
    start_job(0, 64, 8, 64);
    run_own(1, 3, 8);    // R8 runs on to the boundary
    run_own(2, 0, 9);    // R9 retry, same plan next
    run_own(3, 2, 9);    // R9 repeated plan, R10 disconnect at an unaligned point
    run_own(0, 0, 10);   // R10 plain up to the boundary
    finish_job(10);

    // R8 on a plain ownership: release at once
    start_job(1, 10, 8, 16);
    run_own(1, 2, 8);
    finish_job(8);

    // R10 disconnect landing on a boundary keeps write-and-invalidate
    start_job(0, 32, 4, 16);
    run_own(3, 3, 10);
    run_own(0, 0, 10);
    finish_job(10);

    // R11 zero-length job and R1 maximum of zero treated as one
    start_job(7, 0, 8, 8);
    #1;
    check(done === 1'b1 && bus_req === 1'b0, "R11 zero count", done, 1);
    start_job(2, 3, 4, 0);
    finish_job(1);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule